// File: doc/BRIEF.md
# Random Card Index Generator with Repeat Rejection

This block hands out random slot numbers for a card-value memory. A Monte Carlo game engine uses it to deal cards. Reading the memory at the returned slot gives the dealt card, so drawing a slot number is the same as drawing a card. The generator holds one 32-bit linear-feedback shift register per index bit, each with its own seed. On every draw attempt all registers advance by one step together. Bit k of the candidate index is the fresh feedback bit that register k has just produced.

A candidate index is rejected in two cases: it lies at or beyond the live deck size, or it was already dealt in the current game. After a rejection the registers step again on the next cycle. A bit vector holds one flag per slot and records what has been dealt. A clear pulse empties it between simulated games.

Requests use a valid/ready pair, and results use a valid/ready pair. A request is taken only when `req_ready` is high. A result holds its value until the consumer takes it. The seed port, the deck size and the clear input are plain control pins. The deck size must stay constant while a draw is outstanding.

Top module: `card_index_gen`

## Requirements
- R1: After reset, `idx_valid` is low and the dealt set is empty. `req_ready` is high whenever `deck_size` is nonzero.
- R2: Each register uses the polynomial x^32+x^22+x^2+x+1. On a step it shifts toward the MSB and loads bit 0 with the XOR of bits 31, 21, 1 and 0. A register steps exactly once per draw attempt and at no other time.
- R3: Bit k of a candidate index (bit 0 is the LSB) equals the feedback bit that register k produces on that attempt.
- R4: While `seed_we` is high, register `seed_sel` loads `seed_data` on the clock edge. A zero seed is replaced with 32'h6A09E667.
- R5: A candidate greater than or equal to `deck_size` is discarded, and another attempt follows on the next cycle.
- R6: A candidate already in the dealt set is discarded and retried in the same way. An accepted index is added to the set, so no index is returned twice between clears.
- R7: A request taken at clock edge t makes attempts at edges t+1, t+2 and so on. If attempt n succeeds, `idx_valid` is high after edge t+n. `idx` then stays stable and `req_ready` stays low until `idx_ready` is sampled high.
- R8: When every slot below `deck_size` has been dealt, `req_ready` is low and requests are ignored. This includes `deck_size` = 0.
- R9: A `clear` pulse empties the dealt set. If it falls on the same edge as an acceptance, the clear wins and the new index is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_we | input | 1 | Seed write strobe |
| seed_sel | input | 2 | Register selected for the seed write |
| seed_data | input | 32 | Seed value |
| deck_size | input | 5 | Number of live slots; values above 16 act as 16 |
| clear | input | 1 | Empties the dealt set |
| req_valid | input | 1 | Request for a new index |
| req_ready | output | 1 | Request can be taken |
| idx_valid | output | 1 | `idx` holds a fresh index |
| idx_ready | input | 1 | Consumer takes the index |
| idx | output | 4 | Dealt slot index |

## Verification
The hardest case to reach is a `clear` that lands on the exact edge where a candidate is accepted. That edge depends on how many random rejections come first. The bench carries its own copy of the polynomial and seeds, so it knows how many attempts each draw will need and can raise `clear` on that edge. It uses a one-slot deck, where the only sign of whether slot 0 was recorded is `req_ready`. Full sixteen-card and ten-card deals then run every rejection path, and each draw's index and latency are compared with the bench's own prediction.

// File: rtl/cig_pkg.sv
package cig_pkg;
  localparam int LFSR_W = 32;
  // taps for x^32 + x^22 + x^2 + x + 1 : state bits 31, 21, 1, 0
  localparam logic [LFSR_W-1:0] TAP_MASK   = 32'h8020_0003;
  localparam logic [LFSR_W-1:0] SEED_SUBST = 32'h6A09_E667;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DRAW = 2'd1,
    ST_HOLD = 2'd2
  } gen_state_e;

  function automatic logic lfsr_fb(input logic [LFSR_W-1:0] s);
    return ^(s & TAP_MASK);
  endfunction
endpackage

// File: rtl/cig_lane.sv
module cig_lane
  import cig_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RST_SEED = SEED_SUBST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              step,
  output logic              fb
);
  logic [LFSR_W-1:0] state_q;

  assign fb = lfsr_fb(state_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        state_q <= RST_SEED;
    else if (load)     state_q <= (seed == '0) ? SEED_SUBST : seed;
    else if (step)     state_q <= {state_q[LFSR_W-2:0], fb};
  end

  // R4
  nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R4
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && seed == '0 |=> state_q != '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(state_q));
endmodule

// File: rtl/cig_tracker.sv
module cig_tracker #(
  parameter int IDX_W  = 4,
  localparam int SLOTS  = 1 << IDX_W,
  localparam int DECK_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mark,
  input  logic [IDX_W-1:0]  probe,
  input  logic [DECK_W-1:0] deck,
  output logic              seen,
  output logic              full,
  output logic [SLOTS-1:0]  vis
);
  logic [SLOTS-1:0]  vis_q;
  logic [DECK_W-1:0] live_cnt;

  assign vis  = vis_q;
  assign seen = vis_q[probe];

  always_comb begin
    live_cnt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (DECK_W'(i) < deck && vis_q[i]) live_cnt = live_cnt + 1'b1;
    end
  end

  assign full = (live_cnt >= deck);

  always_ff @(posedge clk) begin
    if (!rst_n)     vis_q <= '0;
    else if (clr)   vis_q <= '0;
    else if (mark)  vis_q[probe] <= 1'b1;
  end

  // R8
  full_no_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !mark);
endmodule

// File: rtl/card_index_gen.sv
module card_index_gen
  import cig_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int IDX_W  = NUM_LANES,
  localparam int SLOTS  = 1 << IDX_W,
  localparam int DECK_W = IDX_W + 1,
  localparam int SEL_W  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_we,
  input  logic [SEL_W-1:0]  seed_sel,
  input  logic [31:0]       seed_data,
  input  logic [DECK_W-1:0] deck_size,
  input  logic              clear,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              idx_valid,
  input  logic              idx_ready,
  output logic [IDX_W-1:0]  idx
);
  gen_state_e        st_q;
  logic [IDX_W-1:0]  cand;
  logic [IDX_W-1:0]  idx_q;
  logic [DECK_W-1:0] deck_eff;
  logic              stepping, accept, seen, full;
  logic [SLOTS-1:0]  vis;

  assign deck_eff = (deck_size > DECK_W'(SLOTS)) ? DECK_W'(SLOTS) : deck_size;
  assign stepping = (st_q == ST_DRAW);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    cig_lane #(
      .RST_SEED(SEED_SUBST ^ (32'(k + 1) * 32'h0101_0101))
    ) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .load (seed_we && seed_sel == SEL_W'(k)),
      .seed (seed_data),
      .step (stepping),
      .fb   (cand[k])
    );
  end

  assign accept = stepping && ({1'b0, cand} < deck_eff) && !seen;

  cig_tracker #(.IDX_W(IDX_W)) u_track (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clear),
    .mark (accept),
    .probe(cand),
    .deck (deck_eff),
    .seen (seen),
    .full (full),
    .vis  (vis)
  );

  assign req_ready = (st_q == ST_IDLE) && !full;
  assign idx_valid = (st_q == ST_HOLD);
  assign idx       = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid && req_ready) st_q <= ST_DRAW;
        ST_DRAW: if (accept) begin
          st_q  <= ST_HOLD;
          idx_q <= cand;
        end
        ST_HOLD: if (idx_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid && !idx_ready |=> idx_valid && $stable(idx));

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_valid |-> !req_ready);

  // R5
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idx_valid) |-> {1'b0, idx} < deck_eff);

  // R6
  grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idx_valid) && !$past(clear) |->
      $countones(vis) == $past($countones(vis)) + 1);
endmodule

// File: tb/sim_card_index_gen.sv
module sim_card_index_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_we = 1'b0;
  logic [1:0]  seed_sel = '0;
  logic [31:0] seed_data = '0;
  logic [4:0]  deck_size = 5'd16;
  logic        clear = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        idx_valid;
  logic        idx_ready = 1'b0;
  logic [3:0]  idx;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] ms [4];
  bit          mv [16];
  bit          got_seen [16];

  always #10 clk = ~clk;

  card_index_gen u0 (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_sel(seed_sel),
    .seed_data(seed_data), .deck_size(deck_size), .clear(clear),
    .req_valid(req_valid), .req_ready(req_ready), .idx_valid(idx_valid),
    .idx_ready(idx_ready), .idx(idx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic model_clear();
    for (int i = 0; i < 16; i++) mv[i] = 1'b0;
  endtask

  // polynomial x^32+x^22+x^2+x+1, one step per attempt
  task automatic model_draw(input int deck, output int ix, output int n);
    int c;
    n = 0;
    do begin
      c = 0;
      for (int k = 0; k < 4; k++) begin
        logic fb;
        fb = ms[k][31] ^ ms[k][21] ^ ms[k][1] ^ ms[k][0];
        c = c | (int'(fb) << k);
        ms[k] = {ms[k][30:0], fb};
      end
      n++;
    end while (!(c < deck && !mv[c]) && n < 5000);
    ix = c;
    mv[c] = 1'b1;
  endtask

  task automatic load_seed(input int lane, input logic [31:0] v);
    @(negedge clk);
    seed_we = 1'b1; seed_sel = 2'(lane); seed_data = v;
    @(negedge clk);
    seed_we = 1'b0;
    ms[lane] = (v == 32'd0) ? 32'h6A09_E667 : v;
  endtask

  task automatic do_draw(input int deck, input bit clr_on_mark, input int stall);
    int ex, en, cnt, clr_at;
    bit got;
    model_draw(deck, ex, en);
    clr_at = clr_on_mark ? en : -1;
    @(negedge clk);
    check(req_ready == 1'b1, "R7 req_ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0; got = 1'b0;
    while (!got && cnt < 6000) begin
      if (cnt + 1 == clr_at) clear = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clear = 1'b0;
      cnt++;
      if (idx_valid) got = 1'b1;
    end
    if (clr_on_mark) model_clear();
    check(got, "R7 idx_valid arrives", got, 1);
    // R3 R5 R6: index value from the bench's own lane model
    check(idx == 4'(ex), "R3 R5 R6 index value", idx, ex);
    // R2 R7: one attempt per cycle after acceptance
    check(cnt == en, "R2 R7 draw latency", cnt, en);
    if (!clr_on_mark) begin
      check(!got_seen[idx], "R6 no repeat in game", got_seen[idx], 0);
      got_seen[idx] = 1'b1;
    end
    for (int s = 0; s < stall; s++) begin
      @(posedge clk);
      @(negedge clk);
      check(idx_valid && idx == 4'(ex) && !req_ready, "R7 held under back-pressure", idx, ex);
    end
    idx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    idx_ready = 1'b0;
    check(!idx_valid, "R7 valid drops after take", idx_valid, 0);
  endtask

  task automatic game_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    for (int i = 0; i < 16; i++) got_seen[i] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ms[i] = 32'h6A09_E667 ^ (32'(i + 1) * 32'h0101_0101);
    model_clear();
    for (int i = 0; i < 16; i++) got_seen[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!idx_valid, "R1 reset idx_valid", idx_valid, 0);
    check(req_ready, "R1 reset req_ready", req_ready, 1);

    // R4: distinct seeds, lane 2 given zero
    load_seed(0, 32'h1234_5678);
    load_seed(1, 32'h9ABC_DEF1);
    load_seed(2, 32'h0000_0000);
    load_seed(3, 32'h0F0F_1357);
    check(req_ready, "R4 seeds loaded, idle", req_ready, 1);

    // full 16-card deal, one draw stalled
    deck_size = 5'd16;
    for (int d = 0; d < 16; d++) do_draw(16, 1'b0, (d == 4) ? 3 : 0);
    @(negedge clk);
    // R8
    check(!req_ready, "R8 deck exhausted", req_ready, 0);
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    check(!idx_valid, "R8 request ignored when full", idx_valid, 0);

    // R9 clear reopens the deck
    game_clear();
    check(req_ready, "R9 clear empties set", req_ready, 1);
    deck_size = 5'd0;
    @(negedge clk);
    check(!req_ready, "R8 zero deck", req_ready, 0);

    // R5 ten-card deck
    deck_size = 5'd10;
    for (int d = 0; d < 10; d++) do_draw(10, 1'b0, 0);
    @(negedge clk);
    check(!req_ready, "R8 ten-card deck exhausted", req_ready, 0);

    // R9 clear coincides with acceptance
    game_clear();
    deck_size = 5'd1;
    do_draw(1, 1'b1, 0);
    @(negedge clk);
    check(req_ready, "R9 clear beats mark", req_ready, 1);
    do_draw(1, 1'b0, 0);
    @(negedge clk);
    check(!req_ready, "R6 single slot dealt", req_ready, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule